// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. The write side and the read side each run on their own clock. Each side has its own status flags. The write side reports full and almost-full. The read side reports empty and almost-empty. Each flag is active low and is registered in the clock domain that owns it. The two pointers cross between the clock domains as Gray codes. Each crossing passes through two synchronizer flops. As a result, a flag may be slow to deassert. A flag never asserts late in its own domain.

The level on the shared control pin `wen2_ld` is captured while reset is held. The captured level picks one of two modes, and the mode holds until the next reset.
- In dual-enable mode the pin is a second, active-high write enable.
- In load mode the pin is an active-low strobe. Each strobed write-clock edge stores the data input into the next of four offset registers instead of the FIFO.

The almost-empty threshold and the almost-full threshold are built from those offset registers. The read side has two active-low read enables and a registered output word. An output-enable pin controls a separate drive-enable output, which stands in for a tri-state port.

Top module: `dual_clk_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers return to location zero and `dout` is cleared to 0. In the same condition `full_n` and `afull_n` go high, and `empty_n` and `aempty_n` go low.
- R2: The level of `wen2_ld` is captured on every write-clock edge that sees `rst_n` low. A captured 1 selects dual-enable mode and a captured 0 selects load mode. The mode does not change while `rst_n` stays high. In dual-enable mode a cycle with `wen1_n`=0 and `wen2_ld`=0 changes no offset register.
- R3: A word is stored on a write-clock edge only if three conditions hold: `wen1_n`=0, `wen2_ld`=1 and `full_n`=1. This rule applies in both modes. A write attempted while `full_n` is low is dropped.
- R4: In load mode, each write-clock edge with `wen1_n`=0 and `wen2_ld`=0 stores `din` into one offset register. The registers are taken in a fixed order: almost-empty low part, almost-empty high part, almost-full low part, almost-full high part. After the fourth load the order wraps to the first register. Reset sets the sequence back to the first register. Reset also sets both thresholds back to 7, with the low parts at 7 and the high parts at 0.
- R5: An offset load never writes the storage and never moves the write pointer.
- R6: On a read-clock edge where `ren1_n`=0, `ren2_n`=0 and `empty_n`=1, the oldest word is loaded into `dout`. On every other read-clock edge `dout` keeps its value. Read requests made while `empty_n` is low are ignored.
- R7: `dout_en` is the inverse of `oe_n`, combinationally.
- R8: `empty_n` is low exactly when the FIFO holds no words. It updates on the read clock and goes high no later than the third read-clock edge after a write. `full_n` goes low on the write-clock edge that stores word number DEPTH (default 512).
- R9: `aempty_n` is low while occupancy is at or below the almost-empty threshold. The threshold is the two almost-empty parts concatenated, high over low, and truncated to the pointer index width. `aempty_n` updates on the read clock.
- R10: `afull_n` is low while free space (DEPTH minus occupancy) is at or below the almost-full threshold, which is formed the same way as the almost-empty one. `afull_n` updates on the write clock, on the edge of the write that crosses the threshold.
- R11: Words come out in the order they were written, with no loss and no duplication, across a full fill and a full drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the window in which the mode is captured |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable (active high) or offset-load strobe (active low), depending on the mode |
| din | input | 9 | Write data, and offset data in load mode |
| ren1_n | input | 1 | Read enable, active low |
| ren2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Registered read data |
| dout_en | output | 1 | High when `dout` should drive the bus |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read-clock domain |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| afull_n | output | 1 | Almost-full flag, active low, write-clock domain |

## Verification
Results in the same clock domain as their stimulus are due on that stimulus edge:
- `full_n` and `afull_n` on the edge of the write that crosses the threshold.
- `dout` on the read edge.
- Offset loads take effect on the load edge.

The bench checks these at the falling edge that follows. A result that depends on the other domain needs two synchronizer edges plus one flag register. These are the empty flags after writes and the full flags after reads. For these, the bench waits six edges of each clock before sampling. `dout_en` is combinational and is checked one nanosecond after `oe_n` changes.

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo #(
  parameter int DW = 9,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [DW-1:0] din,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [DW-1:0] DEF_LO = DW'(7);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic          mode_ld;
  logic [AW:0]   wbin, wgray, rg1, rg2;
  logic [1:0]    idx;
  logic [DW-1:0] offr [4];
  logic [AW-1:0] ae_off, af_off;
  logic          wr_go, ld_go;
  logic [AW:0]   wbin_nx, rbin_w, cnt_w, free_w;

  assign ae_off  = AW'({offr[1], offr[0]});
  assign af_off  = AW'({offr[3], offr[2]});
  assign wr_go   = !wen1_n && wen2_ld && full_n;
  assign ld_go   = mode_ld && !wen1_n && !wen2_ld;
  assign wbin_nx = wbin + (AW+1)'(wr_go);
  assign rbin_w  = g2b(rg2);
  assign cnt_w   = wbin_nx - rbin_w;
  assign free_w  = DEPTH_V - cnt_w;

  always_ff @(posedge wclk)
    if (!rst_n) mode_ld <= !wen2_ld;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rg1     <= '0;
      rg2     <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      idx     <= '0;
      offr[0] <= DEF_LO;
      offr[1] <= '0;
      offr[2] <= DEF_LO;
      offr[3] <= '0;
    end else begin
      rg1     <= rgray;
      rg2     <= rg1;
      wbin    <= wbin_nx;
      wgray   <= wbin_nx ^ (wbin_nx >> 1);
      full_n  <= cnt_w != DEPTH_V;
      afull_n <= free_w > {1'b0, af_off};
      if (ld_go) begin
        offr[idx] <= din;
        idx       <= idx + 2'd1;
      end
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= din;

  // read domain
  logic [AW:0]   rbin, rgray, wg1, wg2;
  logic          rd_go;
  logic [AW:0]   rbin_nx, wbin_r, cnt_r;
  logic [DW-1:0] q;

  assign rd_go   = !ren1_n && !ren2_n && empty_n;
  assign rbin_nx = rbin + (AW+1)'(rd_go);
  assign wbin_r  = g2b(wg2);
  assign cnt_r   = wbin_r - rbin_nx;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wg1      <= '0;
      wg2      <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      q        <= '0;
    end else begin
      wg1      <= wgray;
      wg2      <= wg1;
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      empty_n  <= cnt_r != '0;
      aempty_n <= cnt_r > {1'b0, ae_off};
      if (rd_go) q <= mem[rbin[AW-1:0]];
    end

  assign dout    = q;
  assign dout_en = !oe_n;

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> wbin == $past(wbin));
  assert_occupancy_bound_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    (wbin - rbin_w) <= DEPTH_V);
  assert_load_no_store_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    ld_go |=> wbin == $past(wbin));
  assert_mode_held_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_ld));
  assert_no_underflow_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin) && $stable(q));
endmodule

// File: tb/sim_dual_clk_fifo.sv
`timescale 1ns/1ps
module sim_dual_clk_fifo;
  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_en, empty_n, aempty_n, full_n, afull_n;
  int total = 0, bad = 0;

  always #10 wclk = ~wclk;
  initial begin #5; forever #10 rclk = ~rclk; end

  dual_clk_fifo u0 (.wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en), .empty_n(empty_n), .aempty_n(aempty_n),
    .full_n(full_n), .afull_n(afull_n));

  function automatic logic [8:0] word(int i);
    return 9'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic do_reset(logic pin);
    @(negedge wclk);
    rst_n = 0; wen2_ld = pin; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    wen2_ld = 1;
    settle();
  endtask

  task automatic push_n(int n, int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen1_n = 0; wen2_ld = 1; din = word(base + i);
    end
    @(negedge wclk);
    wen1_n = 1;
  endtask

  task automatic load(logic [8:0] v);
    @(negedge wclk);
    wen1_n = 0; wen2_ld = 0; din = v;
    @(negedge wclk);
    wen1_n = 1; wen2_ld = 1;
  endtask

  task automatic pop_n(int n, int base, string tag);
    @(negedge rclk);
    ren1_n = 0; ren2_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      if (i == n - 1) begin ren1_n = 1; ren2_n = 1; end
      chk(tag, dout, word(base + i));
    end
  endtask

  task automatic t_reset();
    @(negedge wclk); rst_n = 0;
    #1;
    chk("R1 empty_n", 9'(empty_n), 9'd0);
    chk("R1 aempty_n", 9'(aempty_n), 9'd0);
    chk("R1 full_n", 9'(full_n), 9'd1);
    chk("R1 afull_n", 9'(afull_n), 9'd1);
    chk("R1 dout", dout, 9'd0);
    do_reset(1'b1);
  endtask

  task automatic t_oe();
    oe_n = 0; #1; chk("R7 oe low", 9'(dout_en), 9'd1);
    oe_n = 1; #1; chk("R7 oe high", 9'(dout_en), 9'd0);
  endtask

  task automatic t_dual_basic();
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) load(9'd1);
    @(negedge wclk); wen1_n = 0; wen2_ld = 0; din = 9'h155;
    @(negedge wclk); wen1_n = 1; wen2_ld = 1;
    settle();
    chk("R3 wen2 low no write", 9'(empty_n), 9'd0);
    push_n(1, 0);
    settle();
    chk("R8 empty_n after write", 9'(empty_n), 9'd1);
    push_n(2, 1);
    settle();
    chk("R2 dual mode ignores load", 9'(aempty_n), 9'd0);
    push_n(4, 3);
    settle();
    chk("R9 seven words", 9'(aempty_n), 9'd0);
    push_n(1, 7);
    settle();
    chk("R9 eight words", 9'(aempty_n), 9'd1);
    @(negedge rclk); ren1_n = 0; ren2_n = 1;
    @(negedge rclk); ren1_n = 1;
    chk("R6 one enable holds", dout, 9'd0);
    pop_n(8, 0, "R11 order");
    settle();
    chk("R8 empty after drain", 9'(empty_n), 9'd0);
    @(negedge rclk); ren1_n = 0; ren2_n = 0;
    repeat (2) @(negedge rclk);
    ren1_n = 1; ren2_n = 1;
    chk("R6 read when empty", dout, word(7));
  endtask

  task automatic t_full();
    do_reset(1'b1);
    push_n(504, 0);
    chk("R10 free 8", 9'(afull_n), 9'd1);
    push_n(1, 504);
    chk("R10 free 7", 9'(afull_n), 9'd0);
    push_n(6, 505);
    chk("R8 511 not full", 9'(full_n), 9'd1);
    push_n(1, 511);
    chk("R8 full on 512th", 9'(full_n), 9'd0);
    @(negedge wclk); wen1_n = 0; wen2_ld = 1; din = 9'h1AA;
    @(negedge wclk); wen1_n = 1;
    settle();
    pop_n(512, 0, "R11 full drain");
    settle();
    chk("R3 drop when full", 9'(empty_n), 9'd0);
    chk("R8 full_n recovers", 9'(full_n), 9'd1);
    chk("R10 afull_n recovers", 9'(afull_n), 9'd1);
  endtask

  task automatic t_load();
    do_reset(1'b0);
    load(9'd2); load(9'd0); load(9'd3); load(9'd0);
    settle();
    chk("R5 load no store", 9'(empty_n), 9'd0);
    push_n(2, 0);
    settle();
    chk("R4 ae offset 2 at 2", 9'(aempty_n), 9'd0);
    push_n(1, 2);
    settle();
    chk("R4 ae offset 2 at 3", 9'(aempty_n), 9'd1);
    push_n(505, 3);
    chk("R4 af offset 3 at 508", 9'(afull_n), 9'd1);
    push_n(1, 508);
    chk("R10 af offset 3 at 509", 9'(afull_n), 9'd0);
    settle();
    pop_n(509, 0, "R11 load mode data");
    load(9'd5);
    push_n(5, 600);
    settle();
    chk("R4 wrap ae 5 at 5", 9'(aempty_n), 9'd0);
    push_n(1, 605);
    settle();
    chk("R4 wrap ae 5 at 6", 9'(aempty_n), 9'd1);
    pop_n(6, 600, "R11 after wrap");
    do_reset(1'b0);
    load(9'd1);
    push_n(1, 0);
    settle();
    chk("R4 index reset at 1", 9'(aempty_n), 9'd0);
    push_n(1, 1);
    settle();
    chk("R4 index reset at 2", 9'(aempty_n), 9'd1);
    pop_n(2, 0, "R11 after reset");
    do_reset(1'b0);
    push_n(7, 0);
    settle();
    chk("R4 default restored", 9'(aempty_n), 9'd0);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_oe();
    t_dual_basic();
    t_full();
    t_load();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule